// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block serves a fork request issued by a running hardware thread inside one virtual processing element that can hold up to sixteen thread contexts. When the request is sampled, it looks at every context's state flags, halt bit and binding, finds the lowest-numbered context that is free for dynamic allocation, and emits a one-cycle commit. The commit carries everything the register files need to start that context: the context index, its restart address, one general register selector with its value, and a freshly composed status word.

If no context qualifies, the same commit cycle instead raises a thread fault and records exception cause 1. Only one request is in flight at a time. The requester keeps the request high until it sees the done pulse, and it must not issue a new request in the cycle that follows done. Register storage and pipeline hookup belong to the surrounding logic.

Top module: `fork_alloc`

## Requirements
- R1: After reset, `done`, `fault` and `ctx_we` are 0 and `exc_code` is 0.
- R2: Only contexts with index 0 through `ctx_last` are candidates, so the number scanned is `ctx_last` + 1. A free context above `ctx_last` is never chosen.
- R3: When several contexts qualify, the one with the lowest index is chosen, and exactly one context is written per request.
- R4: A context qualifies only when all of these hold: its `ctx_dyn` bit is 1, its `ctx_halt` bit is 0, its `ctx_act` bit is 0, and its binding field in `ctx_vpe` (bits i*4 to i*4+3 for context i) equals `my_vpe`.
- R5: On success, `new_pc` equals `op_s`, `gpr_sel` equals `rd_sel`, and `gpr_data` equals `op_t`, all as sampled with the request.
- R6: On success, `new_stat` holds the following fields: run state 0 in [1:0], delay-slot flag 0 in [2], dirty flag 1 in [3], and activated flag 1 in [4]. The forker's mode `my_mode` is in [6:5] and the forker's `my_asid` is in [14:7].
- R7: When no context qualifies, `fault` is 1 together with `done`, `ctx_we` stays 0, and `exc_code` becomes 1. `exc_code` keeps its value after a successful fork.
- R8: `done` goes high exactly one clock edge after a request is sampled and stays high for one cycle. A request held high through its done cycle produces only one result.
- R9: With no request, `done`, `fault` and `ctx_we` remain 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Fork request, held until done |
| ctx_last | input | 4 | Highest context index to scan (count minus one) |
| my_vpe | input | 4 | Processing element of the forking thread |
| my_mode | input | 2 | Privilege mode of the forking thread |
| my_asid | input | 8 | Address-space ID of the forking thread |
| op_s | input | 32 | Restart address operand |
| op_t | input | 32 | Value for the new context's general register |
| rd_sel | input | 5 | Destination general register selector |
| ctx_dyn | input | 16 | Per-context dynamic-allocation flag |
| ctx_halt | input | 16 | Per-context halt bit |
| ctx_act | input | 16 | Per-context activated flag |
| ctx_vpe | input | 64 | Per-context binding, 4 bits per context |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Thread fault, valid with done |
| exc_code | output | 3 | Exception cause field |
| ctx_we | output | 1 | Write strobe for the chosen context |
| pick_idx | output | 4 | Index of the chosen context |
| new_pc | output | 32 | Restart address for the chosen context |
| gpr_sel | output | 5 | General register to write in the chosen context |
| gpr_data | output | 32 | Value for that register |
| new_stat | output | 15 | Status word for the chosen context |

## Verification
Every result comes from a single register stage. Outputs driven before edge N appear after edge N, and stay for that cycle only. The bench drives a request on a falling edge and requires `done` on the very next falling edge. It then requires `done` to be low one falling edge later while the request is still high. A monitor compares each done cycle against an expected item queued by the driver when the stimulus was applied. For `exc_code`, the queued item carries the sticky value predicted from the fault history.

// File: rtl/fork_alloc.sv
module fork_alloc #(
  parameter int MAX_CTX = 16,
  parameter int VPE_W   = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int MODE_W  = 2,
  parameter int ASID_W  = 8,
  parameter int CNT_W   = $clog2(MAX_CTX),
  parameter int STAT_W  = 5 + MODE_W + ASID_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [CNT_W-1:0]         ctx_last,
  input  logic [VPE_W-1:0]         my_vpe,
  input  logic [MODE_W-1:0]        my_mode,
  input  logic [ASID_W-1:0]        my_asid,
  input  logic [ADDR_W-1:0]        op_s,
  input  logic [DATA_W-1:0]        op_t,
  input  logic [REG_W-1:0]         rd_sel,
  input  logic [MAX_CTX-1:0]       ctx_dyn,
  input  logic [MAX_CTX-1:0]       ctx_halt,
  input  logic [MAX_CTX-1:0]       ctx_act,
  input  logic [MAX_CTX*VPE_W-1:0] ctx_vpe,
  output logic                     done,
  output logic                     fault,
  output logic [2:0]               exc_code,
  output logic                     ctx_we,
  output logic [CNT_W-1:0]         pick_idx,
  output logic [ADDR_W-1:0]        new_pc,
  output logic [REG_W-1:0]         gpr_sel,
  output logic [DATA_W-1:0]        gpr_data,
  output logic [STAT_W-1:0]        new_stat
);

  localparam logic [2:0] EXC_NO_CTX = 3'd1;

  logic [MAX_CTX-1:0] elig;
  logic               hit;
  logic [CNT_W-1:0]   pick_c;
  logic               fire;

  genvar g;
  generate
    for (g = 0; g < MAX_CTX; g++) begin : g_elig
      assign elig[g] = (CNT_W'(g) <= ctx_last) & ctx_dyn[g] & ~ctx_halt[g] & ~ctx_act[g]
                       & (ctx_vpe[g*VPE_W +: VPE_W] == my_vpe);
    end
  endgenerate

  always_comb begin
    hit    = 1'b0;
    pick_c = '0;
    for (int i = MAX_CTX - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit    = 1'b1;
        pick_c = CNT_W'(i);
      end
    end
  end

  assign fire = req & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fault    <= 1'b0;
      ctx_we   <= 1'b0;
      exc_code <= '0;
      pick_idx <= '0;
      new_pc   <= '0;
      gpr_sel  <= '0;
      gpr_data <= '0;
      new_stat <= '0;
    end else begin
      done   <= fire;
      fault  <= fire & ~hit;
      ctx_we <= fire & hit;
      if (fire && !hit) exc_code <= EXC_NO_CTX;
      if (fire && hit) begin
        pick_idx <= pick_c;
        new_pc   <= op_s;
        gpr_sel  <= rd_sel;
        gpr_data <= op_t;
        new_stat <= {my_asid, my_mode, 1'b1, 1'b1, 1'b0, 2'b00};
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(req)); // R8
  AST_FAULT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> (done && !ctx_we)); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) done |-> (ctx_we ^ fault)); // R3
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> exc_code == EXC_NO_CTX); // R7
  AST_PICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ctx_we |-> pick_idx <= $past(ctx_last)); // R2
  AST_STAT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) ctx_we |-> new_stat[4:0] == 5'b11000); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$past(req) |-> !done); // R9

endmodule

// File: tb/sim_fork_alloc.sv
module sim_fork_alloc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req = 1'b0;
  logic [3:0]  ctx_last = '0;
  logic [3:0]  my_vpe = '0;
  logic [1:0]  my_mode = '0;
  logic [7:0]  my_asid = '0;
  logic [31:0] op_s = '0, op_t = '0;
  logic [4:0]  rd_sel = '0;
  logic [15:0] ctx_dyn = '0, ctx_halt = '0, ctx_act = '0;
  logic [63:0] ctx_vpe = '0;
  logic        done, fault, ctx_we;
  logic [2:0]  exc_code;
  logic [3:0]  pick_idx;
  logic [31:0] new_pc, gpr_data;
  logic [4:0]  gpr_sel;
  logic [14:0] new_stat;

  fork_alloc u0 (.*);

  typedef struct packed {
    logic        flt;
    logic [3:0]  idx;
    logic [31:0] pc;
    logic [4:0]  sel;
    logic [31:0] data;
    logic [14:0] stat;
    logic [2:0]  exc;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic [2:0] exc_model = '0;
  bit reported = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  function automatic exp_t predict();
    exp_t e;
    bit found = 0;
    e = '0;
    for (int i = 0; i <= 15; i++) begin
      if (!found && i <= int'(ctx_last) && ctx_dyn[i] && !ctx_halt[i] && !ctx_act[i]
          && ctx_vpe[i*4 +: 4] == my_vpe) begin
        found = 1;
        e.idx = 4'(i);
      end
    end
    e.flt = !found;
    if (!found) exc_model = 3'd1;
    e.exc = exc_model;
    e.pc = op_s;
    e.sel = rd_sel;
    e.data = op_t;
    e.stat = {my_asid, my_mode, 5'b11000};
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) begin
        chk("R8 unexpected done", 1, 0);
      end else begin
        e = q.pop_front();
        chk("R7 fault", {31'd0, fault}, {31'd0, e.flt});
        chk("R7 exc_code", {29'd0, exc_code}, {29'd0, e.exc});
        chk("R3 write strobe", {31'd0, ctx_we}, {31'd0, ~e.flt});
        if (!e.flt) begin
          chk("R3 pick_idx", {28'd0, pick_idx}, {28'd0, e.idx});
          chk("R5 new_pc", new_pc, e.pc);
          chk("R5 gpr_sel", {27'd0, gpr_sel}, {27'd0, e.sel});
          chk("R5 gpr_data", gpr_data, e.data);
          chk("R6 new_stat", {17'd0, new_stat}, {17'd0, e.stat});
        end
      end
    end
  end

  task automatic do_fork();
    exp_t e;
    e = predict();
    req = 1'b1;
    q.push_back(e);
    @(negedge clk);
    chk("R8 done one edge after request", {31'd0, done}, 1);
    @(negedge clk);
    chk("R8 done lasts one cycle", {31'd0, done}, 0);
    req = 1'b0;
  endtask

  task automatic set_ctx(input int i, input bit dyn, input bit hlt, input bit act, input logic [3:0] v);
    ctx_dyn[i] = dyn; ctx_halt[i] = hlt; ctx_act[i] = act; ctx_vpe[i*4 +: 4] = v;
  endtask

  task automatic clear_ctx();
    for (int i = 0; i < 16; i++) set_ctx(i, 0, 0, 0, 4'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done at reset", {31'd0, done}, 0);
    chk("R1 fault at reset", {31'd0, fault}, 0);
    chk("R1 ctx_we at reset", {31'd0, ctx_we}, 0);
    chk("R1 exc_code at reset", {29'd0, exc_code}, 0);

    my_vpe = 4'd3; my_mode = 2'd2; my_asid = 8'hA5; op_s = 32'h0040_1000; op_t = 32'hDEAD_BEEF; rd_sel = 5'd17;

    // R3: all qualify, lowest wins
    ctx_last = 4'd15;
    for (int i = 0; i < 16; i++) set_ctx(i, 1, 0, 0, 4'd3);
    @(negedge clk); do_fork();

    // R4: each disqualifying condition in turn, ctx 4 qualifies
    clear_ctx();
    set_ctx(0, 1, 1, 0, 4'd3);
    set_ctx(1, 1, 0, 1, 4'd3);
    set_ctx(2, 0, 0, 0, 4'd3);
    set_ctx(3, 1, 0, 0, 4'd7);
    set_ctx(4, 1, 0, 0, 4'd3);
    op_s = 32'h1234_5678; rd_sel = 5'd31; my_mode = 2'd1; my_asid = 8'h3C;
    @(negedge clk); do_fork();

    // R7: none qualify -> fault, cause 1
    set_ctx(4, 1, 1, 0, 4'd3);
    @(negedge clk); do_fork();

    // R7: cause stays after success; R3 with two candidates
    clear_ctx();
    set_ctx(9, 1, 0, 0, 4'd3);
    set_ctx(5, 1, 0, 0, 4'd3);
    @(negedge clk); do_fork();

    // R2: only ctx 10 free but scan limit 7 -> fault; limit 10 -> pick 10
    clear_ctx();
    set_ctx(10, 1, 0, 0, 4'd3);
    ctx_last = 4'd7;
    @(negedge clk); do_fork();
    ctx_last = 4'd10;
    @(negedge clk); do_fork();

    // R2: top index at full count
    clear_ctx();
    set_ctx(15, 1, 0, 0, 4'd3);
    ctx_last = 4'd15;
    @(negedge clk); do_fork();
    ctx_last = 4'd0;
    set_ctx(0, 1, 0, 0, 4'd3);
    @(negedge clk); do_fork();

    // R9: idle, no activity
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 idle done", {31'd0, done}, 0);
      chk("R9 idle ctx_we", {31'd0, ctx_we}, 0);
      chk("R9 idle fault", {31'd0, fault}, 0);
    end

    // R4 R5 R6: varied patterns
    for (int n = 0; n < 60; n++) begin
      ctx_last = 4'($urandom_range(0, 15));
      ctx_dyn = 16'($urandom); ctx_halt = 16'($urandom) & 16'($urandom);
      ctx_act = 16'($urandom) & 16'($urandom);
      for (int i = 0; i < 16; i++) ctx_vpe[i*4 +: 4] = ($urandom_range(0, 2) == 0) ? 4'd9 : my_vpe;
      op_s = $urandom; op_t = $urandom; rd_sel = 5'($urandom);
      my_mode = 2'($urandom); my_asid = 8'($urandom);
      @(negedge clk); do_fork();
    end

    repeat (3) @(negedge clk);
    chk("R8 all results seen", q.size(), 0);
    summary();
  end
endmodule